// File: doc/BRIEF.md
# Converter Result Bank with Interrupt

This block sits behind a conversion sequencer and keeps the results it produces. Each result arrives as a one-cycle strobe that carries a channel number and a 12-bit code. The code is written into the data register of that channel and into one global data register. The global register also records which channel produced it. Every data register has a completion flag and a lost-result flag. Both flags clear when software reads that register.

Software reaches the bank over a simple register bus. It has a read strobe, a write strobe, a word address and returned read data. Read data is combinational while the read strobe is high. Flag clearing takes effect at the clock edge that ends the read.

A packed status word mirrors all per-channel flags. An interrupt-enable register selects the interrupt source. In one mode the source is a masked OR of the per-channel completion flags. In the other mode it is the global completion flag alone. The interrupt line is registered and stays high until its contributing flags are cleared.

Top module: `adc_result_bank`

## Requirements
- R1: When `res_valid` is high, the data register of channel `res_chan` and the global data register capture `res_value`, and the global register captures `res_chan`. In the next cycle the completion flag of both registers is 1. Stored values do not change in cycles without `res_valid`.
- R2: Word addresses 0 to 7 are the per-channel data registers and address 8 is the global data register. In these words, bit 31 is the completion flag, bit 27 is the lost-result flag, bits 26:24 hold the channel number (global register only, zero in per-channel registers) and bits 15:4 hold the result. All other bits read 0, and unmapped addresses 12 to 15 read 0.
- R3: A read of a data register returns its current flags. At that clock edge it clears that register's completion and lost-result flags, and no other register's flags.
- R4: The lost-result flag of a register is set when a new result lands in it while its completion flag is 1 and it is not being read in the same cycle. It stays set until that register is read. A read and a new result in the same cycle leave the completion flag at 1 and the lost-result flag at 0.
- R5: A write to address 11 (the control register) clears the global completion and lost-result flags but leaves the per-channel flags alone. A result arriving in the same cycle wins, and the completion flag ends at 1.
- R6: Address 10 is the interrupt-enable register, which is readable. Bits 7:0 enable per-channel completion flags and bit 8 selects global mode. Address 9 is the status word: bits 7:0 are the per-channel completion flags, bits 15:8 the per-channel lost-result flags, and bit 16 is 1 when any enabled channel's completion flag is 1. Reading the status word clears nothing.
- R7: A write to address 10 loads the interrupt-enable register from `bus_wdata[8:0]`. Writes to addresses 0 to 9 have no effect.
- R8: `irq` equals, one cycle later, the global completion flag when enable bit 8 is 1. When bit 8 is 0, it equals the OR of the per-channel completion flags masked by enable bits 7:0.
- R9: The full-scale codes 0x000 and 0xFFF are stored and read back unchanged.
- R10: After reset, all flags, values, channel numbers and enables are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; clears flags of the addressed data register |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 9 | Write data (interrupt-enable value) |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high, zero otherwise |
| res_valid | input | 1 | A new conversion result is present this cycle |
| res_chan | input | 3 | Channel number of the result |
| res_value | input | 12 | Conversion code |
| irq | output | 1 | Registered interrupt request |

## Verification
The properties assume that `bus_rd`, `bus_wr` and `res_valid` are single-cycle strobes sampled at the rising edge. They also assume that the inputs are held at zero while reset is asserted, so the one-cycle look-backs after reset see quiet inputs. The bench drives each strobe for exactly one cycle from the falling edge and keeps the strobes low throughout reset. It deliberately stacks a read on a new result for the same register, and a control write on a new result, to cover the precedence rules.

// File: rtl/adc_rb_pkg.sv
// Package: shared sizes, word addresses and field positions of the result bank.
// Assumes eight channels and 12-bit codes; the read word layout depends on both.
package adc_rb_pkg;
    localparam int NUM_CH   = 8;
    localparam int VAL_W    = 12;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam int EN_W     = NUM_CH + 1;

    localparam logic [ADDR_W-1:0] A_GLOBAL = ADDR_W'(NUM_CH);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(NUM_CH + 1);
    localparam logic [ADDR_W-1:0] A_INTEN  = ADDR_W'(NUM_CH + 2);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(NUM_CH + 3);

    localparam int DONE_BIT = 31;
    localparam int OVR_BIT  = 27;
    localparam int CH_LSB   = 24;
    localparam int VAL_LSB  = 4;

    // Assemble one data-register word from its fields.
    function automatic logic [DATA_W-1:0] pack_word(
        input logic             done,
        input logic             ovr,
        input logic [CH_W-1:0]  ch,
        input logic [VAL_W-1:0] v
    );
        logic [DATA_W-1:0] w;
        w = '0;
        w[DONE_BIT]          = done;
        w[OVR_BIT]           = ovr;
        w[CH_LSB +: CH_W]    = ch;
        w[VAL_LSB +: VAL_W]  = v;
        return w;
    endfunction
endpackage

// File: rtl/adc_result_slot.sv
// Module: one result register with its completion and lost-result flags.
// Assumes load, consume and wipe are single-cycle strobes; load has priority.
module adc_result_slot #(
    parameter int VAL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VAL_W-1:0] load_val,
    input  logic             consume,
    input  logic             wipe,
    output logic             done_o,
    output logic             ovr_o,
    output logic [VAL_W-1:0] val_o
);
    logic             done_q;
    logic             ovr_q;
    logic [VAL_W-1:0] val_q;

    // Capture a new code or clear the flags on read or wipe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
            val_q  <= '0;
        end else if (load) begin
            val_q  <= load_val;
            done_q <= 1'b1;
            ovr_q  <= (done_q & ~consume) | (ovr_q & ~consume);
        end else if (consume || wipe) begin
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
        end
    end

    assign done_o = done_q;
    assign ovr_o  = ovr_q;
    assign val_o  = val_q;
endmodule

// File: rtl/adc_irq_gen.sv
// Module: registered interrupt request from masked channel flags or the global flag.
// Assumes the mask and mode come from a register that changes only on bus writes.
module adc_irq_gen #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] done_vec,
    input  logic [NUM_CH-1:0] ch_mask,
    input  logic              glob_mode,
    input  logic              glob_done,
    output logic              any_ch_o,
    output logic              irq_o
);
    logic irq_q;

    // Combinational: any enabled channel has a completed result.
    assign any_ch_o = |(done_vec & ch_mask);

    // Register the selected interrupt source.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= glob_mode ? glob_done : any_ch_o;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/adc_result_bank.sv
// Module: per-channel and global result registers, status word and interrupt.
// Assumes single-cycle bus and result strobes; reads have no wait states.
module adc_result_bank
    import adc_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [EN_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [VAL_W-1:0]  res_value,
    output logic              irq
);
    logic [NUM_CH-1:0] ch_done;
    logic [NUM_CH-1:0] ch_ovr;
    logic [NUM_CH-1:0] ch_load;
    logic [NUM_CH-1:0] ch_take;
    logic [VAL_W-1:0]  ch_val [NUM_CH];

    logic              g_done;
    logic              g_ovr;
    logic [VAL_W-1:0]  g_val;
    logic [CH_W-1:0]   g_chan;
    logic              g_take;
    logic              g_wipe;

    logic [EN_W-1:0]   en_q;
    logic              ch_any;

    // One result slot per channel, loaded by channel match, cleared by its own read.
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
            assign ch_load[c] = res_valid && (res_chan == CH_W'(c));
            assign ch_take[c] = bus_rd && (bus_addr == ADDR_W'(c));
            adc_result_slot #(.VAL_W(VAL_W)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (ch_load[c]),
                .load_val (res_value),
                .consume  (ch_take[c]),
                .wipe     (1'b0),
                .done_o   (ch_done[c]),
                .ovr_o    (ch_ovr[c]),
                .val_o    (ch_val[c])
            );
        end
    endgenerate

    assign g_take = bus_rd && (bus_addr == A_GLOBAL);
    assign g_wipe = bus_wr && (bus_addr == A_CTRL);

    adc_result_slot #(.VAL_W(VAL_W)) u_glob (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (res_valid),
        .load_val (res_value),
        .consume  (g_take),
        .wipe     (g_wipe),
        .done_o   (g_done),
        .ovr_o    (g_ovr),
        .val_o    (g_val)
    );

    // Remember which channel produced the latest result.
    always_ff @(posedge clk) begin
        if (!rst_n)         g_chan <= '0;
        else if (res_valid) g_chan <= res_chan;
    end

    // Interrupt-enable register, written only at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n)                               en_q <= '0;
        else if (bus_wr && bus_addr == A_INTEN)   en_q <= bus_wdata;
    end

    adc_irq_gen #(.NUM_CH(NUM_CH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_vec  (ch_done),
        .ch_mask   (en_q[NUM_CH-1:0]),
        .glob_mode (en_q[NUM_CH]),
        .glob_done (g_done),
        .any_ch_o  (ch_any),
        .irq_o     (irq)
    );

    // Read multiplexer; zero when no read is requested.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr < A_GLOBAL) begin
                bus_rdata = pack_word(ch_done[bus_addr[CH_W-1:0]],
                                      ch_ovr[bus_addr[CH_W-1:0]],
                                      '0,
                                      ch_val[bus_addr[CH_W-1:0]]);
            end else if (bus_addr == A_GLOBAL) begin
                bus_rdata = pack_word(g_done, g_ovr, g_chan, g_val);
            end else if (bus_addr == A_STATUS) begin
                bus_rdata[NUM_CH-1:0]        = ch_done;
                bus_rdata[2*NUM_CH-1:NUM_CH] = ch_ovr;
                bus_rdata[2*NUM_CH]          = ch_any;
            end else if (bus_addr == A_INTEN) begin
                bus_rdata[EN_W-1:0] = en_q;
            end
        end
    end
endmodule

// File: rtl/adc_result_bank_chk.sv
// Module: property checker for the result bank, attached by bind.
// Assumes strobes are single-cycle and inputs are quiet during reset.
module adc_result_bank_chk
    import adc_rb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              res_valid,
    input logic [CH_W-1:0]   res_chan,
    input logic              irq,
    input logic [NUM_CH-1:0] ch_done,
    input logic [NUM_CH-1:0] ch_ovr,
    input logic              g_done,
    input logic              g_ovr,
    input logic [VAL_W-1:0]  g_val,
    input logic [EN_W-1:0]   en_q
);
    AST_CH_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> ch_done[$past(res_chan)]); // R1
    AST_GLOB_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> g_done); // R1
    AST_VAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(g_val)); // R1
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr <= A_GLOBAL) |->
        (bus_rdata[30:28] == 3'd0 && bus_rdata[23:16] == 8'd0 && bus_rdata[3:0] == 4'd0)); // R2
    AST_GLOB_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_GLOBAL && !res_valid) |=> (!g_done && !g_ovr)); // R3
    AST_OVR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_ovr & ~ch_done) == '0) && (!g_ovr || g_done)); // R4
    AST_CTRL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL && !res_valid) |=> !g_done); // R5
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((|(ch_done & en_q[NUM_CH-1:0])) || g_done)); // R8
endmodule

bind adc_result_bank adc_result_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .res_valid (res_valid),
    .res_chan  (res_chan),
    .irq       (irq),
    .ch_done   (ch_done),
    .ch_ovr    (ch_ovr),
    .g_done    (g_done),
    .g_ovr     (g_ovr),
    .g_val     (g_val),
    .en_q      (en_q)
);

// File: tb/adc_result_bank_bench.sv
// Bench: behavioural reference model of the result bank, compared every clock.
module adc_result_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [8:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        res_valid = 1'b0;
    logic [2:0]  res_chan = '0;
    logic [11:0] res_value = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Reference state
    bit m_done [8];
    bit m_ovr  [8];
    int m_val  [8];
    bit m_gd, m_go;
    int m_gv, m_gc, m_en;
    bit m_irq;

    always #10 clk = ~clk;

    adc_result_bank u_adc_result_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .res_valid(res_valid), .res_chan(res_chan), .res_value(res_value),
        .irq(irq)
    );

    function automatic logic [31:0] exp_word(input int a);
        logic [31:0] w;
        w = '0;
        if (a < 8) begin
            w[31] = m_done[a];
            w[27] = m_ovr[a];
            w[15:4] = 12'(m_val[a]);
        end else if (a == 8) begin
            w[31] = m_gd;
            w[27] = m_go;
            w[26:24] = 3'(m_gc);
            w[15:4] = 12'(m_gv);
        end else if (a == 9) begin
            for (int c = 0; c < 8; c++) begin
                w[c] = m_done[c];
                w[8 + c] = m_ovr[c];
                if (m_done[c] && m_en[c]) w[16] = 1'b1;
            end
        end else if (a == 10) begin
            w[8:0] = 9'(m_en);
        end
        return w;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus/result cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(input bit wr, input bit rd, input int addr, input int wd,
                        input bit rv, input int rch, input int rval, input string tag);
        bit irq_n;
        bit any;
        bit load, take;
        bus_wr = wr; bus_rd = rd; bus_addr = 4'(addr); bus_wdata = 9'(wd);
        res_valid = rv; res_chan = 3'(rch); res_value = 12'(rval);
        #2;
        if (rd) check(bus_rdata, exp_word(addr), tag);
        check({31'd0, irq}, {31'd0, m_irq}, "R8");
        @(posedge clk);
        any = 1'b0;
        for (int c = 0; c < 8; c++) if (m_done[c] && m_en[c]) any = 1'b1;
        irq_n = m_en[8] ? m_gd : any;
        for (int c = 0; c < 8; c++) begin
            load = rv && (rch == c);
            take = rd && (addr == c);
            if (load) begin
                m_ovr[c]  = (m_done[c] || m_ovr[c]) && !take;
                m_done[c] = 1'b1;
                m_val[c]  = rval;
            end else if (take) begin
                m_done[c] = 1'b0;
                m_ovr[c]  = 1'b0;
            end
        end
        if (rv) begin
            m_go = (m_gd || m_go) && !(rd && addr == 8);
            m_gd = 1'b1;
            m_gv = rval;
            m_gc = rch;
        end else if ((rd && addr == 8) || (wr && addr == 11)) begin
            m_gd = 1'b0;
            m_go = 1'b0;
        end
        if (wr && addr == 10) m_en = wd & 9'h1FF;
        m_irq = irq_n;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; res_valid = 1'b0;
    endtask

    task automatic rd(input int addr, input string tag);
        step(0, 1, addr, 0, 0, 0, 0, tag);
    endtask

    task automatic res(input int ch, input int v);
        step(0, 0, 0, 0, 1, ch, v, "R1");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, "R8");
    endtask

    initial begin
        for (int c = 0; c < 8; c++) begin m_done[c] = 0; m_ovr[c] = 0; m_val[c] = 0; end
        m_gd = 0; m_go = 0; m_gv = 0; m_gc = 0; m_en = 0; m_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state of every address, including unmapped ones (R2)
        for (int a = 0; a < 16; a++) rd(a, "R10");

        // R7: enable register write/readback; writes elsewhere ignored
        step(1, 0, 10, 9'h105, 0, 0, 0, "R7");
        rd(10, "R7");
        step(1, 0, 0, 9'h1FF, 0, 0, 0, "R7");
        step(1, 0, 9, 9'h1FF, 0, 0, 0, "R7");
        rd(0, "R7");
        rd(9, "R7");
        rd(10, "R7");

        // R1: capture into channel and global registers; global mode interrupt (R8)
        res(3, 12'hABC);
        idle(2);
        rd(3, "R1");
        rd(3, "R3");
        rd(8, "R2");
        idle(2);

        // R9: full-scale codes
        res(0, 12'h000);
        res(7, 12'hFFF);
        rd(0, "R9");
        rd(7, "R9");
        rd(8, "R9");

        // R4: lost result, then read stacked on a new result
        res(2, 12'h111);
        res(2, 12'h222);
        rd(9, "R6");
        rd(2, "R4");
        rd(8, "R4");
        res(5, 12'h055);
        step(0, 1, 5, 0, 1, 5, 12'h066, "R4");
        rd(5, "R4");
        rd(5, "R4");

        // R3: reading one channel leaves others set
        res(1, 12'h101);
        res(6, 12'h606);
        rd(1, "R3");
        rd(9, "R3");
        rd(6, "R3");
        rd(8, "R3");

        // R5: control write clears only global flags; result wins on collision
        res(4, 12'h404);
        step(1, 0, 11, 0, 0, 0, 0, "R5");
        rd(8, "R5");
        rd(4, "R5");
        step(1, 0, 11, 0, 1, 2, 12'h202, "R5");
        rd(8, "R5");
        rd(2, "R5");

        // R6/R8: per-channel mode with mask on channels 1 and 4
        step(1, 0, 10, 9'h012, 0, 0, 0, "R7");
        res(0, 12'h00F);
        idle(2);
        res(4, 12'h444);
        idle(2);
        rd(9, "R6");
        rd(9, "R6");
        rd(4, "R8");
        idle(2);
        res(1, 12'h777);
        res(1, 12'h778);
        rd(9, "R6");
        rd(1, "R8");
        idle(2);
        rd(0, "R3");
        rd(8, "R3");
        idle(1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule